// File: doc/BRIEF.md
# Home-Node Directory Coherence Controller

This block sits at the home node of a distributed-memory multiprocessor and keeps one directory entry per memory block it owns. Each entry records whether the block is cached nowhere (Uncached), held read-only by a set of nodes (Shared), or held writable by a single node (Exclusive). A Shared entry carries a bit vector of sharers, and an Exclusive entry carries the identity of the owner. The block also contains the home memory for those blocks, cleared to zero at reset.

Every node has its own request port carrying a read miss, a write miss or a data writeback, with a block address and, for a writeback, the data. When several ports request at once, the lowest-numbered node wins. One request is carried through to completion before the next is accepted, so the directory alone sets the order of competing writes.

Four valid/ready message channels connect the block to the rest of the system. Data replies go back to the requester. Invalidates go to sharers, one node per message. Fetch messages go to an owner, and the owner's data comes back on a response channel.

Top module: `coh_dir_home`

## Requirements
- R1: After reset every block is Uncached with no sharers, home memory reads as zero, no output channel is valid and no request port is ready while no request is presented.
- R2: A read miss (kind code 0) to an Uncached block is answered on the reply channel with the home memory data, and the block becomes Shared with the requester as its only sharer.
- R3: A write miss (kind code 1) to an Uncached block is answered with the home memory data, and the block becomes Exclusive owned by the requester.
- R4: A read miss to a Shared block is answered with the home memory data, adds the requester to the sharers, and sends no invalidate.
- R5: A write miss to a Shared block sends one invalidate to each sharer other than the requester, in ascending node order, one per accepted handshake. It then replies with the memory data, and the block becomes Exclusive owned by the requester. The requester is never invalidated.
- R6: A read miss to an Exclusive block sends a fetch to the owner and waits for the owner's data. It writes that data to home memory and replies with it, and the block becomes Shared with both the old owner and the requester as sharers.
- R7: A write miss to an Exclusive block fetches the owner's data, writes it to memory and replies with it. The block stays Exclusive with the requester recorded as the new owner.
- R8: A writeback (kind code 2) from the owner of an Exclusive block writes its data to home memory and makes the block Uncached. No message is sent for it.
- R9: A writeback from a node that is not the owner, or to a block that is not Exclusive, changes neither memory nor the directory and sends no message.
- R10: When several nodes request in the same cycle, only the lowest-indexed one sees ready. The others are accepted later, in index order.
- R11: While a request is being serviced, no request port is ready, and at most one of the reply, invalidate and fetch channels is valid.
- R12: A valid output message keeps its node and payload unchanged until it is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | NODES | Request present, one bit per node |
| req_ready | output | NODES | Request accepted, one bit per node |
| req_kind | input | 2*NODES | Per-node request kind: 0 read miss, 1 write miss, 2 writeback |
| req_addr | input | NODES*ADDR_W | Per-node block address |
| req_wdata | input | NODES*DATA_W | Per-node writeback data |
| rsp_valid | output | 1 | Data reply valid |
| rsp_ready | input | 1 | Data reply accepted |
| rsp_node | output | NODE_W | Destination node of the reply |
| rsp_addr | output | ADDR_W | Block address of the reply |
| rsp_data | output | DATA_W | Block data |
| inv_valid | output | 1 | Invalidate valid |
| inv_ready | input | 1 | Invalidate accepted |
| inv_node | output | NODE_W | Node to invalidate |
| inv_addr | output | ADDR_W | Block to invalidate |
| fetch_valid | output | 1 | Fetch-from-owner valid |
| fetch_ready | input | 1 | Fetch accepted |
| fetch_node | output | NODE_W | Owner being fetched from |
| fetch_addr | output | ADDR_W | Block being fetched |
| fdat_valid | input | 1 | Owner data response valid |
| fdat_ready | output | 1 | Owner data response accepted |
| fdat_data | input | DATA_W | Owner data |

## Verification
A wrong sharer vector stays hidden until a later write miss to that block. It then shows up as a missing invalidate, an extra invalidate, or one sent to the requester. A wrong owner shows up on the next miss to the block, as a fetch aimed at the wrong node. A wrong state shows up as a fetch that should not occur, or a reply with stale data where the fetched data was expected. Because of this, the stimulus chains misses on one block so that every entry update is exposed by the very next request to that block, within a few cycles of acceptance. Writebacks that must be ignored are followed at once by a read whose reply data shows whether memory was touched.

// File: rtl/dir_pkg.sv
package dir_pkg;
  typedef enum logic [1:0] {DS_UNC = 2'd0, DS_SHR = 2'd1, DS_EXC = 2'd2} dstate_e;
  typedef enum logic [1:0] {RK_READ = 2'd0, RK_WRITE = 2'd1, RK_WBACK = 2'd2} rkind_e;
  typedef enum logic [2:0] {CS_IDLE, CS_INVAL, CS_FREQ, CS_FWAIT, CS_REPLY} cstate_e;
endpackage

// File: rtl/dir_arb.sv
// Fixed-priority pick: lowest set bit wins.
module dir_arb #(
  parameter int N = 4,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req,
  output logic [N-1:0]  gnt,
  output logic [IW-1:0] idx,
  output logic          any
);
  always_comb begin
    gnt = '0;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        gnt    = '0;
        gnt[i] = 1'b1;
        idx    = IW'(i);
      end
    end
  end
  assign any = |req;
endmodule

// File: rtl/dir_store.sv
// Home memory: one word per block, cleared by reset.
module dir_store #(
  parameter int DEPTH = 8,
  parameter int DW    = 16,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr,
  output logic [DW-1:0] rdata,
  input  logic          we,
  input  logic [DW-1:0] wdata
);
  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (we) begin
      mem_q[addr] <= wdata;
    end
  end
  assign rdata = mem_q[addr];
endmodule

// File: rtl/dir_table.sv
// Directory entries: state, sharer vector, owner.
module dir_table
  import dir_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int N     = 4,
  localparam int AW   = $clog2(DEPTH),
  localparam int IW   = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr,
  output dstate_e       rd_st,
  output logic [N-1:0]  rd_shr,
  output logic [IW-1:0] rd_own,
  input  logic          we,
  input  dstate_e       wr_st,
  input  logic [N-1:0]  wr_shr,
  input  logic [IW-1:0] wr_own
);
  dstate_e       st_q  [DEPTH];
  logic [N-1:0]  shr_q [DEPTH];
  logic [IW-1:0] own_q [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) begin
        st_q[i]  <= DS_UNC;
        shr_q[i] <= '0;
        own_q[i] <= '0;
      end
    end else if (we) begin
      st_q[addr]  <= wr_st;
      shr_q[addr] <= wr_shr;
      own_q[addr] <= wr_own;
    end
  end
  assign rd_st  = st_q[addr];
  assign rd_shr = shr_q[addr];
  assign rd_own = own_q[addr];
endmodule

// File: rtl/coh_dir_home.sv
module coh_dir_home
  import dir_pkg::*;
#(
  parameter int NODES  = 4,
  parameter int BLOCKS = 8,
  parameter int DATA_W = 16,
  localparam int NODE_W = (NODES > 1) ? $clog2(NODES) : 1,
  localparam int ADDR_W = $clog2(BLOCKS)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NODES-1:0]         req_valid,
  output logic [NODES-1:0]         req_ready,
  input  logic [2*NODES-1:0]       req_kind,
  input  logic [NODES*ADDR_W-1:0]  req_addr,
  input  logic [NODES*DATA_W-1:0]  req_wdata,
  output logic                     rsp_valid,
  input  logic                     rsp_ready,
  output logic [NODE_W-1:0]        rsp_node,
  output logic [ADDR_W-1:0]        rsp_addr,
  output logic [DATA_W-1:0]        rsp_data,
  output logic                     inv_valid,
  input  logic                     inv_ready,
  output logic [NODE_W-1:0]        inv_node,
  output logic [ADDR_W-1:0]        inv_addr,
  output logic                     fetch_valid,
  input  logic                     fetch_ready,
  output logic [NODE_W-1:0]        fetch_node,
  output logic [ADDR_W-1:0]        fetch_addr,
  input  logic                     fdat_valid,
  output logic                     fdat_ready,
  input  logic [DATA_W-1:0]        fdat_data
);
  cstate_e             state_q, state_d;
  logic [NODE_W-1:0]   cur_node_q, cur_node_d;
  logic [1:0]          cur_kind_q, cur_kind_d;
  logic [ADDR_W-1:0]   cur_addr_q, cur_addr_d;
  logic [NODES-1:0]    inv_mask_q, inv_mask_d;
  logic [DATA_W-1:0]   rsp_data_q, rsp_data_d;

  // request arbitration
  logic [NODES-1:0]    gnt;
  logic [NODE_W-1:0]   g_idx;
  logic                g_any;
  dir_arb #(.N(NODES)) u_req_pick (.req(req_valid), .gnt(gnt), .idx(g_idx), .any(g_any));

  logic [1:0]          sel_kind;
  logic [ADDR_W-1:0]   sel_addr;
  logic [DATA_W-1:0]   sel_wdata;
  assign sel_kind  = req_kind[g_idx*2 +: 2];
  assign sel_addr  = req_addr[g_idx*ADDR_W +: ADDR_W];
  assign sel_wdata = req_wdata[g_idx*DATA_W +: DATA_W];

  // invalidate target pick
  logic [NODES-1:0]    inv_onehot;
  logic [NODE_W-1:0]   inv_idx;
  logic                inv_any;
  dir_arb #(.N(NODES)) u_inv_pick (.req(inv_mask_q), .gnt(inv_onehot), .idx(inv_idx), .any(inv_any));

  logic                idle;
  logic [ADDR_W-1:0]   look_addr;
  assign idle      = (state_q == CS_IDLE);
  assign look_addr = idle ? sel_addr : cur_addr_q;

  // directory entry and home memory
  dstate_e             t_st, t_wst;
  logic [NODES-1:0]    t_shr, t_wshr;
  logic [NODE_W-1:0]   t_own, t_wown;
  logic                t_we;
  dir_table #(.DEPTH(BLOCKS), .N(NODES)) u_table (
    .clk(clk), .rst_n(rst_n), .addr(look_addr),
    .rd_st(t_st), .rd_shr(t_shr), .rd_own(t_own),
    .we(t_we), .wr_st(t_wst), .wr_shr(t_wshr), .wr_own(t_wown));

  logic [DATA_W-1:0]   m_rdata, m_wdata;
  logic                m_we;
  assign m_wdata = idle ? sel_wdata : fdat_data;
  dir_store #(.DEPTH(BLOCKS), .DW(DATA_W)) u_store (
    .clk(clk), .rst_n(rst_n), .addr(look_addr), .rdata(m_rdata),
    .we(m_we), .wdata(m_wdata));

  logic [NODES-1:0]    g_left;
  assign g_left = (t_st == DS_SHR) ? (t_shr & ~gnt) : '0;

  // next-state logic
  always_comb begin
    state_d    = state_q;
    cur_node_d = cur_node_q;
    cur_kind_d = cur_kind_q;
    cur_addr_d = cur_addr_q;
    inv_mask_d = inv_mask_q;
    rsp_data_d = rsp_data_q;
    t_we       = 1'b0;
    t_wst      = t_st;
    t_wshr     = t_shr;
    t_wown     = t_own;
    m_we       = 1'b0;
    unique case (state_q)
      CS_IDLE: if (g_any) begin
        cur_node_d = g_idx;
        cur_kind_d = sel_kind;
        cur_addr_d = sel_addr;
        case (sel_kind)
          RK_READ: begin
            if (t_st == DS_EXC) state_d = CS_FREQ;
            else begin
              rsp_data_d = m_rdata;
              t_we       = 1'b1;
              t_wst      = DS_SHR;
              t_wshr     = ((t_st == DS_SHR) ? t_shr : '0) | gnt;
              state_d    = CS_REPLY;
            end
          end
          RK_WRITE: begin
            if (t_st == DS_EXC) state_d = CS_FREQ;
            else begin
              rsp_data_d = m_rdata;
              t_we       = 1'b1;
              t_wst      = DS_EXC;
              t_wshr     = '0;
              t_wown     = g_idx;
              inv_mask_d = g_left;
              state_d    = (|g_left) ? CS_INVAL : CS_REPLY;
            end
          end
          RK_WBACK: begin
            if (t_st == DS_EXC && t_own == g_idx) begin
              m_we   = 1'b1;
              t_we   = 1'b1;
              t_wst  = DS_UNC;
              t_wshr = '0;
            end
          end
          default: ;
        endcase
      end
      CS_INVAL: if (inv_ready) begin
        inv_mask_d = inv_mask_q & ~inv_onehot;
        if (inv_mask_d == '0) state_d = CS_REPLY;
      end
      CS_FREQ: if (fetch_ready) state_d = CS_FWAIT;
      CS_FWAIT: if (fdat_valid) begin
        m_we       = 1'b1;
        rsp_data_d = fdat_data;
        t_we       = 1'b1;
        if (cur_kind_q == RK_READ) begin
          t_wst  = DS_SHR;
          t_wshr = (NODES'(1) << t_own) | (NODES'(1) << cur_node_q);
        end else begin
          t_wst  = DS_EXC;
          t_wshr = '0;
          t_wown = cur_node_q;
        end
        state_d = CS_REPLY;
      end
      CS_REPLY: if (rsp_ready) state_d = CS_IDLE;
      default: state_d = CS_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= CS_IDLE;
      cur_node_q <= '0;
      cur_kind_q <= '0;
      cur_addr_q <= '0;
      inv_mask_q <= '0;
      rsp_data_q <= '0;
    end else begin
      state_q    <= state_d;
      cur_node_q <= cur_node_d;
      cur_kind_q <= cur_kind_d;
      cur_addr_q <= cur_addr_d;
      inv_mask_q <= inv_mask_d;
      rsp_data_q <= rsp_data_d;
    end
  end

  assign req_ready   = idle ? gnt : '0;
  assign rsp_valid   = (state_q == CS_REPLY);
  assign rsp_node    = cur_node_q;
  assign rsp_addr    = cur_addr_q;
  assign rsp_data    = rsp_data_q;
  assign inv_valid   = (state_q == CS_INVAL) && inv_any;
  assign inv_node    = inv_idx;
  assign inv_addr    = cur_addr_q;
  assign fetch_valid = (state_q == CS_FREQ);
  assign fetch_node  = t_own;
  assign fetch_addr  = cur_addr_q;
  assign fdat_ready  = (state_q == CS_FWAIT);
endmodule

// File: rtl/dir_home_chk.sv
module dir_home_chk #(
  parameter int NODES  = 4,
  parameter int DATA_W = 16,
  localparam int NODE_W = (NODES > 1) ? $clog2(NODES) : 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NODES-1:0]  req_valid,
  input logic [NODES-1:0]  req_ready,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic [NODE_W-1:0] rsp_node,
  input logic [DATA_W-1:0] rsp_data,
  input logic              inv_valid,
  input logic              inv_ready,
  input logic [NODE_W-1:0] inv_node,
  input logic              fetch_valid,
  input logic              fetch_ready,
  input logic [NODE_W-1:0] fetch_node,
  input logic [NODE_W-1:0] cur_node
);
  a_r11_one_channel: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rsp_valid, inv_valid, fetch_valid}));
  a_r11_no_accept_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid || inv_valid || fetch_valid) |-> (req_ready == '0));
  a_r10_single_ready: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(req_ready));
  a_r10_lowest_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (|req_ready) |-> (((req_valid & (req_ready - 1'b1)) == '0) && ((req_ready & ~req_valid) == '0)));
  a_r12_rsp_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_node) && $stable(rsp_data)));
  a_r12_inv_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (inv_valid && !inv_ready) |=> (inv_valid && $stable(inv_node)));
  a_r12_fetch_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_valid && !fetch_ready) |=> (fetch_valid && $stable(fetch_node)));
  a_r5_skip_requester: assert property (@(posedge clk) disable iff (!rst_n)
    inv_valid |-> (inv_node != cur_node));
  a_r5_ascending: assert property (@(posedge clk) disable iff (!rst_n)
    (inv_valid && inv_ready) |=> (!inv_valid || (inv_node > $past(inv_node))));
endmodule

bind coh_dir_home dir_home_chk #(.NODES(NODES), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_node(rsp_node), .rsp_data(rsp_data),
  .inv_valid(inv_valid), .inv_ready(inv_ready), .inv_node(inv_node),
  .fetch_valid(fetch_valid), .fetch_ready(fetch_ready), .fetch_node(fetch_node),
  .cur_node(cur_node_q));

// File: tb/coh_dir_home_bench.sv
`timescale 1ns/100ps
module coh_dir_home_bench;
  localparam int N = 4, B = 8, DW = 16, NW = 2, AW = 3;

  logic clk = 1'b0;
  logic rst_n;
  logic [N-1:0]    req_valid;
  logic [N-1:0]    req_ready;
  logic [2*N-1:0]  req_kind;
  logic [N*AW-1:0] req_addr;
  logic [N*DW-1:0] req_wdata;
  logic rsp_valid, rsp_ready, inv_valid, inv_ready, fetch_valid, fetch_ready;
  logic fdat_valid, fdat_ready;
  logic [NW-1:0] rsp_node, inv_node, fetch_node;
  logic [AW-1:0] rsp_addr, inv_addr, fetch_addr;
  logic [DW-1:0] rsp_data, fdat_data;

  always #2.5 clk = ~clk;

  coh_dir_home #(.NODES(N), .BLOCKS(B), .DATA_W(DW)) u_coh_dir_home (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_kind(req_kind), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_node(rsp_node),
    .rsp_addr(rsp_addr), .rsp_data(rsp_data),
    .inv_valid(inv_valid), .inv_ready(inv_ready), .inv_node(inv_node), .inv_addr(inv_addr),
    .fetch_valid(fetch_valid), .fetch_ready(fetch_ready), .fetch_node(fetch_node),
    .fetch_addr(fetch_addr), .fdat_valid(fdat_valid), .fdat_ready(fdat_ready),
    .fdat_data(fdat_data));

  typedef struct packed {
    logic [1:0]  node;
    logic [1:0]  kind;   // 0 read miss, 1 write miss, 2 writeback
    logic [2:0]  addr;
    logic [15:0] wdata;
    logic [3:0]  inv;    // expected invalidate set
    logic        fen;    // fetch expected
    logic [1:0]  fnode;
    logic [15:0] fdata;
    logic        ren;    // reply expected
    logic [15:0] rdata;
    logic [3:0]  rq;     // requirement number for messages
  } vec_t;

  localparam vec_t VECS [15] = '{
    '{2'd1, 2'd0, 3'd2, 16'h0,    4'b0000, 1'b0, 2'd0, 16'h0,    1'b1, 16'h0,    4'd2},  // R2
    '{2'd3, 2'd0, 3'd2, 16'h0,    4'b0000, 1'b0, 2'd0, 16'h0,    1'b1, 16'h0,    4'd4},  // R4
    '{2'd0, 2'd0, 3'd2, 16'h0,    4'b0000, 1'b0, 2'd0, 16'h0,    1'b1, 16'h0,    4'd4},  // R4
    '{2'd1, 2'd1, 3'd2, 16'h0,    4'b1001, 1'b0, 2'd0, 16'h0,    1'b1, 16'h0,    4'd5},  // R5
    '{2'd2, 2'd0, 3'd2, 16'h0,    4'b0000, 1'b1, 2'd1, 16'hA5A5, 1'b1, 16'hA5A5, 4'd6},  // R6
    '{2'd0, 2'd1, 3'd2, 16'h0,    4'b0110, 1'b0, 2'd0, 16'h0,    1'b1, 16'hA5A5, 4'd6},  // R6 both sharers
    '{2'd3, 2'd1, 3'd2, 16'h0,    4'b0000, 1'b1, 2'd0, 16'h1234, 1'b1, 16'h1234, 4'd7},  // R7
    '{2'd2, 2'd2, 3'd2, 16'hBEEF, 4'b0000, 1'b0, 2'd0, 16'h0,    1'b0, 16'h0,    4'd9},  // R9 non-owner
    '{2'd1, 2'd0, 3'd2, 16'h0,    4'b0000, 1'b1, 2'd3, 16'h5555, 1'b1, 16'h5555, 4'd7},  // R7 new owner
    '{2'd3, 2'd2, 3'd2, 16'h7777, 4'b0000, 1'b0, 2'd0, 16'h0,    1'b0, 16'h0,    4'd9},  // R9 not Exclusive
    '{2'd1, 2'd0, 3'd2, 16'h0,    4'b0000, 1'b0, 2'd0, 16'h0,    1'b1, 16'h5555, 4'd9},  // R9 memory intact
    '{2'd2, 2'd1, 3'd5, 16'h0,    4'b0000, 1'b0, 2'd0, 16'h0,    1'b1, 16'h0,    4'd3},  // R3
    '{2'd2, 2'd2, 3'd5, 16'hCAFE, 4'b0000, 1'b0, 2'd0, 16'h0,    1'b0, 16'h0,    4'd8},  // R8
    '{2'd0, 2'd0, 3'd5, 16'h0,    4'b0000, 1'b0, 2'd0, 16'h0,    1'b1, 16'hCAFE, 4'd8},  // R8 Uncached
    '{2'd0, 2'd1, 3'd5, 16'h0,    4'b0000, 1'b0, 2'd0, 16'h0,    1'b1, 16'hCAFE, 4'd5}   // R5 requester skipped
  };

  int n_chk = 0;
  int n_fail = 0;

  task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h at %0t", rq, act, exp, $time);
    end
  endtask

  task automatic set_req(input int n, input logic [1:0] k, input logic [2:0] a, input logic [15:0] d);
    req_valid[n]         = 1'b1;
    req_kind[n*2 +: 2]   = k;
    req_addr[n*AW +: AW] = a;
    req_wdata[n*DW +: DW] = d;
  endtask

  task automatic run_vec(input vec_t v);
    string rq;
    logic [3:0] left;
    bit got_f, got_r;
    int e;
    rq = $sformatf("R%0d", v.rq);
    @(negedge clk);
    set_req(int'(v.node), v.kind, v.addr, v.wdata);
    #1;
    while (!req_ready[v.node]) begin @(negedge clk); #1; end
    @(negedge clk);
    req_valid[v.node] = 1'b0;
    left = v.inv; got_f = 1'b0; got_r = 1'b0;
    for (int c = 0; c < 12 && !got_r; c++) begin
      if (inv_valid) begin
        e = 0;
        for (int i = 3; i >= 0; i--) if (left[i]) e = i;
        chk(left != 0 && int'(inv_node) == e, rq, inv_node, e);
        left[e] = 1'b0;
      end
      if (fetch_valid) begin
        chk(v.fen && fetch_node == v.fnode && fetch_addr == v.addr, rq, fetch_node, v.fnode);
        got_f = 1'b1;
        fdat_valid = 1'b1;
        fdat_data  = v.fdata;
      end
      if (rsp_valid) begin
        chk(rsp_node == v.node && rsp_addr == v.addr, rq, {rsp_node, rsp_addr}, {v.node, v.addr});
        chk(rsp_data == v.rdata, rq, rsp_data, v.rdata);
        got_r = 1'b1;
      end
      if (!got_r) @(negedge clk);
    end
    fdat_valid = 1'b0;
    chk(got_r == v.ren, rq, got_r, v.ren);
    chk(got_f == v.fen, rq, got_f, v.fen);
    chk(left == 4'b0, rq, left, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    req_valid = '0; req_kind = '0; req_addr = '0; req_wdata = '0;
    rsp_ready = 1'b1; inv_ready = 1'b1; fetch_ready = 1'b1;
    fdat_valid = 1'b0; fdat_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: quiet after reset
    chk(!rsp_valid && !inv_valid && !fetch_valid, "R1", {rsp_valid, inv_valid, fetch_valid}, 0);
    chk(req_ready == '0, "R1", req_ready, 0);

    foreach (VECS[i]) run_vec(VECS[i]);

    // R10 / R11 / R12: simultaneous requests, reply back-pressured
    @(negedge clk);
    rsp_ready = 1'b0;
    set_req(3, 2'd0, 3'd7, 16'h0);
    set_req(1, 2'd0, 3'd7, 16'h0);
    #1;
    chk(req_ready == 4'b0010, "R10", req_ready, 4'b0010);
    @(negedge clk);
    req_valid[1] = 1'b0;
    chk(req_ready == '0, "R11", req_ready, 0);
    for (int k = 0; k < 3; k++) begin
      chk(rsp_valid && rsp_node == 2'd1 && rsp_data == 16'h0, "R12", {rsp_valid, rsp_node}, 3'b101);
      @(negedge clk);
    end
    rsp_ready = 1'b1;
    @(negedge clk);
    chk(req_ready == 4'b1000, "R10", req_ready, 4'b1000);
    @(negedge clk);
    req_valid[3] = 1'b0;
    chk(rsp_valid && rsp_node == 2'd3, "R4", {rsp_valid, rsp_node}, 3'b111);
    @(negedge clk);

    // R1: reset clears memory and directory
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    run_vec('{2'd0, 2'd0, 3'd2, 16'h0, 4'b0000, 1'b0, 2'd0, 16'h0, 1'b1, 16'h0, 4'd1});

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule